// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only data cache that sits between a processor load port and a slower lower-level memory. It takes a 40-bit physical byte address and returns the aligned 64-bit word that holds it. The address has three fields. The low six bits locate a byte inside a 64-byte block, and the top three of those six pick one of the eight words. The next nine bits select one of 512 sets. The remaining 25 bits are the tag. Each set has two ways, so 64 KiB of data sits in two banks of 4096 words each. A bank is addressed by the set index followed by the three word-select bits.

A request is accepted while the cache is idle. In the next cycle the cache reads the tags and valid bits of both ways in the indexed set and compares them with the request tag. The word from the matching way is then driven out. On a miss the cache asks the lower memory for the whole block, using an address whose low six bits are zero. It takes in the eight returned 64-bit words in order and writes them into a victim way of the same set. It then marks that way valid with the new tag and repeats the lookup, which now hits and returns the word.

An empty way is always filled before a valid one is replaced. When both ways are valid, an elaboration parameter picks the replacement rule: least recently used (one bit per set), first in first out (one pointer bit per set), or a free-running pseudo-random bit. Only one request is in flight at a time.

Top module: `sa2_read_cache`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0. Every way of every set is empty, so the first read of any address after a reset is a miss.
- R2: On a hit, `rsp_valid` is high for exactly the one cycle after the request is accepted. No lower-memory request is made.
- R3: The address fields are as follows: tag is bits [39:15], set index is bits [14:6] and word select is bits [5:3]. Bits [2:0] have no effect, so reads that differ only in those bits return the same word and hit the same block.
- R4: On a miss, exactly one lower-memory request is made. Its address is the requested address with bits [5:0] cleared. The request and its address stay unchanged until `mem_req_ready` is seen.
- R5: The refill takes eight beats, and beat k is stored as word k of the block. The response comes the cycle after the eighth beat is accepted. Its data is the requested word, and any other word of that block read later hits with the data of its own beat.
- R6: A block can be placed only in the set given by its index bits. It may go in either way, and at most one way of a set ever matches a tag.
- R7: If a way of the set is empty on a miss, the block goes into that empty way (way 0 before way 1). Two blocks with different tags in one set therefore both stay resident.
- R8: With the least-recently-used setting (the default), a miss in a full set evicts the way that was not used most recently. A hit or a fill counts as a use.
- R9: `req_ready` is low from acceptance until the response cycle, and high again in the cycle after it. Each accepted request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_addr | input | 40 | Physical byte address of the read |
| rsp_valid | output | 1 | One-cycle pulse carrying the read result |
| rsp_data | output | 64 | Aligned 64-bit word holding the addressed byte |
| mem_req_valid | output | 1 | Block fetch request to lower memory |
| mem_req_ready | input | 1 | Lower memory takes the fetch request |
| mem_req_addr | output | 40 | Block-aligned fetch address |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_ready | output | 1 | Cache accepts a refill beat |
| mem_rsp_data | input | 64 | Refill beat, words in ascending order |

## Verification
Directed sequences cover several cases. Two tags placed in one set show that both ways stay resident and that the least-recently-used choice differs from a fixed-way choice. A hit made just before a third tag arrives decides which block should survive. Reads that differ only in the byte bits, or only in the word bits, show whether the offset field is split at the right place and whether refill beats land in order. Repeating a read after a mid-run reset shows that the valid bits are cleared. A stretch of random reads over a few tags and sets, including the highest set index, is compared against a bench model of tags, valid bits and recency. It checks the returned data, the hit or miss outcome seen on the lower-memory port, and the hit latency, while the refill beats arrive with random gaps.

// File: rtl/rc_pkg.sv
// Shared types for the two-way read cache.
// Assumes: nothing beyond IEEE 1800-2017.
package rc_pkg;
    // Replacement rule applied when both ways of a set hold valid blocks.
    typedef enum logic [1:0] {REPL_LRU, REPL_FIFO, REPL_RANDOM} repl_e;
    // Controller states.
    typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_MREQ, ST_FILL} st_e;
endpackage

// File: rtl/rc_way.sv
// One way of the cache: a valid bit and a tag per set, plus a data bank of
// SETS*WPB words addressed by {set index, word select}.
// Assumes: the controller never reads and fills the same way in one cycle,
// and no lookup takes place while a fill is partially written.
module rc_way #(
    parameter int TAG_W  = 25,
    parameter int IDX_W  = 9,
    parameter int WSEL_W = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic [WSEL_W-1:0] rd_wsel,
    input  logic              fill_we,
    input  logic [WSEL_W-1:0] fill_wsel,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              tag_we,
    output logic              valid_o,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WORDS = SETS << WSEL_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [WORDS];

    // Valid bits: cleared by reset, set when a completed refill installs a tag.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q      <= '0;
        else if (tag_we)  valid_q[idx] <= 1'b1;
    end

    // Tag and data storage: written on fill, never reset.
    always_ff @(posedge clk) begin
        if (tag_we)  tag_q[idx] <= tag;
        if (fill_we) data_q[{idx, fill_wsel}] <= fill_data;
    end

    // Lookup: valid bit, tag compare and word read for the indexed set.
    always_comb begin
        valid_o = valid_q[idx];
        hit     = valid_o && (tag_q[idx] == tag);
        rd_data = data_q[{idx, rd_wsel}];
    end
endmodule

// File: rtl/rc_victim.sv
// Victim selection for a two-way set. An empty way wins first (way 0 before
// way 1); otherwise the rule picked by POLICY decides.
// Assumes: 'touch' marks a hit in the lookup cycle, 'fill_done' marks the
// cycle a refill installs its tag; idx is the set under consideration.
module rc_victim
    import rc_pkg::*;
#(
    parameter repl_e POLICY = REPL_LRU,
    parameter int    IDX_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       valid_vec,
    input  logic             touch,
    input  logic             touch_way,
    input  logic             fill_done,
    input  logic             fill_way,
    output logic             victim
);
    localparam int SETS = 1 << IDX_W;

    logic policy_pick;

    generate
        if (POLICY == REPL_LRU) begin : g_lru
            logic [SETS-1:0] mru_q;
            logic            unused_fill;
            assign unused_fill = fill_done ^ fill_way;
            // Recency: remember the way used last in each set.
            always_ff @(posedge clk) begin
                if (!rst_n)     mru_q      <= '0;
                else if (touch) mru_q[idx] <= touch_way;
            end
            assign policy_pick = ~mru_q[idx];

            // After a hit in a full set, the other way is the victim (R8).
            assert_lru_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (touch && (&valid_vec)) |=> (!$stable(idx) || (victim != $past(touch_way))));
        end else if (POLICY == REPL_FIFO) begin : g_fifo
            logic [SETS-1:0] next_q;
            logic            unused_touch;
            assign unused_touch = touch ^ touch_way;
            // Round robin: after filling a way, point at the other one.
            always_ff @(posedge clk) begin
                if (!rst_n)         next_q      <= '0;
                else if (fill_done) next_q[idx] <= ~fill_way;
            end
            assign policy_pick = next_q[idx];
        end else begin : g_rand
            logic [15:0] lfsr_q;
            logic        unused_ev;
            assign unused_ev = touch ^ touch_way ^ fill_done ^ fill_way;
            // Free-running 16-bit Fibonacci LFSR.
            always_ff @(posedge clk) begin
                if (!rst_n) lfsr_q <= 16'hACE1;
                else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
            end
            assign policy_pick = lfsr_q[0];
        end
    endgenerate

    // Empty way first, then the policy choice.
    always_comb begin
        if (!valid_vec[0])      victim = 1'b0;
        else if (!valid_vec[1]) victim = 1'b1;
        else                    victim = policy_pick;
    end
endmodule

// File: rtl/sa2_read_cache.sv
// Two-way set-associative read cache with block refill from lower memory.
// Flow: accept request -> lookup both ways -> hit: respond; miss: fetch the
// block, write BEATS words into the victim way, install the tag, re-lookup.
// Assumes: one request in flight; lower memory returns the beats of a block
// in ascending word order after accepting the fetch.
module sa2_read_cache
    import rc_pkg::*;
#(
    parameter int    ADDR_W      = 40,
    parameter int    DATA_W      = 64,
    parameter int    BLOCK_BYTES = 64,
    parameter int    SETS        = 512,
    parameter repl_e POLICY      = REPL_LRU
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAYS   = 2;

    st_e                      state_q;
    logic [ADDR_W-BYTE_W-1:0] addr_q;
    logic [WSEL_W-1:0]        beat_q;
    logic                     victim_q;
    logic                     byte_sel_unused;

    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [WSEL_W-1:0] cur_wsel;
    logic [WAYS-1:0]   hit_vec, valid_vec;
    logic [DATA_W-1:0] way_data [WAYS];
    logic              hit_any, hit_way, victim;
    logic              fill_we, last_beat, fill_done, lookup_hit;

    assign byte_sel_unused = ^req_addr[BYTE_W-1:0];

    // Field split of the latched word address.
    assign cur_wsel = addr_q[WSEL_W-1:0];
    assign cur_idx  = addr_q[WSEL_W +: IDX_W];
    assign cur_tag  = addr_q[WSEL_W+IDX_W +: TAG_W];

    // Handshake and control decode.
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_MREQ);
    assign mem_req_addr  = {cur_tag, cur_idx, {OFF_W{1'b0}}};
    assign mem_rsp_ready = (state_q == ST_FILL);
    assign fill_we       = mem_rsp_ready && mem_rsp_valid;
    assign last_beat     = (beat_q == {WSEL_W{1'b1}});
    assign fill_done     = fill_we && last_beat;
    assign hit_any       = |hit_vec;
    assign hit_way       = hit_vec[1];
    assign lookup_hit    = (state_q == ST_LOOKUP) && hit_any;
    assign rsp_valid     = lookup_hit;
    assign rsp_data      = way_data[hit_way];

    // Two identical ways; fills go only to the chosen victim.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        rc_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (cur_idx),
            .tag      (cur_tag),
            .rd_wsel  (cur_wsel),
            .fill_we  (fill_we && (victim_q == 1'(w))),
            .fill_wsel(beat_q),
            .fill_data(mem_rsp_data),
            .tag_we   (fill_done && (victim_q == 1'(w))),
            .valid_o  (valid_vec[w]),
            .hit      (hit_vec[w]),
            .rd_data  (way_data[w])
        );
    end

    rc_victim #(.POLICY(POLICY), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (cur_idx),
        .valid_vec(valid_vec),
        .touch    (lookup_hit),
        .touch_way(hit_way),
        .fill_done(fill_done),
        .fill_way (victim_q),
        .victim   (victim)
    );

    // Controller: request capture, lookup, fetch and refill sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            beat_q   <= '0;
            victim_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr[ADDR_W-1:BYTE_W];
                    state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: if (hit_any) begin
                    state_q <= ST_IDLE;
                end else begin
                    victim_q <= victim;
                    state_q  <= ST_MREQ;
                end
                ST_MREQ: if (mem_req_ready) begin
                    beat_q  <= '0;
                    state_q <= ST_FILL;
                end
                ST_FILL: if (fill_we) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) state_q <= ST_LOOKUP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // At most one way of a set may match a tag.
    assert_one_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));
    // A pending fetch keeps its request and address.
    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // The last refill beat is followed by the response.
    assert_fill_then_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> rsp_valid);
    // A response returns the cache to idle.
    assert_idle_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));
endmodule

// File: tb/test_sa2_read_cache.sv
module test_sa2_read_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_fetch  = 0;

    // Bench model of tag state (least-recently-used setting).
    logic [24:0] m_tag   [2][512];
    logic        m_valid [2][512];
    logic        m_mru   [512];

    always #5 clk = ~clk;

    sa2_read_cache i_sa2_read_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [63:0] mem_word(input logic [39:0] a);
        logic [36:0] wa;
        wa = a[39:3];
        return {wa[26:0] ^ 27'h5A5A5A5, wa};
    endfunction

    function automatic logic [39:0] mk(input int tag, input int idx, input int w, input int b);
        return {25'(tag), 9'(idx), 3'(w), 3'(b)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 512; s++) begin
            m_valid[0][s] = 1'b0; m_valid[1][s] = 1'b0; m_mru[s] = 1'b0;
        end
    endtask

    // Predicts hit/miss for an address and updates the model.
    function automatic bit model_access(input logic [39:0] a);
        int   s;
        logic [24:0] t;
        logic v;
        s = int'(a[14:6]);
        t = a[39:15];
        for (int w = 0; w < 2; w++)
            if (m_valid[w][s] && m_tag[w][s] == t) begin
                m_mru[s] = 1'(w);
                return 1'b1;
            end
        if (!m_valid[0][s])      v = 1'b0;
        else if (!m_valid[1][s]) v = 1'b1;
        else                     v = ~m_mru[s];
        m_valid[v][s] = 1'b1;
        m_tag[v][s]   = t;
        m_mru[s]      = v;
        return 1'b0;
    endfunction

    // Lower memory: accepts a fetch, returns eight beats with random gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [39:0] blk;
                blk = mem_req_addr;
                n_fetch++;
                check(blk[5:0] == 6'd0, "R4 fetch alignment", 64'(blk), 64'(blk & ~40'h3F));
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int b = 0; b < 8; b++) begin
                    int gap;
                    gap = int'($urandom_range(0, 2));
                    for (int g = 0; g < gap; g++) @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(blk + 40'(b * 8));
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    // One read with full checking of data, hit/miss and handshake timing.
    task automatic do_read(input logic [39:0] a, input string tag);
        bit exp_hit;
        int lat;
        int f0;
        bit busy_ok;
        exp_hit = model_access(a);
        f0 = n_fetch;
        busy_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(rsp_valid, {"R9 response arrives ", tag}, 64'(rsp_valid), 64'd1);
        check(rsp_data == mem_word(a), {"R5 R3 read data ", tag}, rsp_data, mem_word(a));
        check((n_fetch == f0) == exp_hit, {"R6 R7 R8 hit/miss ", tag}, 64'(n_fetch - f0), 64'(!exp_hit));
        if (!exp_hit)
            check(n_fetch == f0 + 1, {"R4 single fetch ", tag}, 64'(n_fetch - f0), 64'd1);
        if (exp_hit)
            check(lat == 1, {"R2 hit latency ", tag}, 64'(lat), 64'd1);
        check(busy_ok, {"R9 busy while in flight ", tag}, 64'(busy_ok), 64'd1);
        @(negedge clk);
        check(req_ready && !rsp_valid, {"R9 idle after response ", tag}, 64'({req_ready, rsp_valid}), 64'b10);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
              64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);

        // R1, R5: first read misses and fills; R3: byte bits ignored
        do_read(mk(5, 3, 2, 0), "first miss R1");
        do_read(mk(5, 3, 2, 7), "byte bits R3");
        do_read(mk(5, 3, 0, 0), "word0 R5");
        do_read(mk(5, 3, 7, 4), "word7 R5");
        // R7: second tag in same set uses empty way, both stay
        do_read(mk(9, 3, 1, 0), "second tag R7");
        do_read(mk(5, 3, 2, 0), "first still R7");
        // R8: third tag evicts least recently used (tag 9)
        do_read(mk(12, 3, 4, 0), "third tag R8");
        do_read(mk(5, 3, 6, 0), "mru kept R8");
        do_read(mk(9, 3, 1, 0), "lru evicted R8");
        // R6: same tag in another set is independent
        do_read(mk(5, 4, 2, 0), "other set R6");
        do_read(mk(5, 511, 2, 0), "top set R6");
        // R1: reset clears valid bits mid-run
        do_reset();
        do_read(mk(5, 3, 2, 0), "after reset R1");

        // Random reads over a small pool of tags and sets
        for (int i = 0; i < 400; i++) begin
            int t, s;
            t = int'($urandom_range(0, 3));
            s = int'($urandom_range(0, 3));
            if (s == 3) s = 511;
            do_read(mk(t, s, int'($urandom_range(0, 7)), int'($urandom_range(0, 7))), "random R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule